// File: doc/BRIEF.md
# Clock source selector with oscillator stabilization wait

This block chooses the system clock source and switches the two oscillators on and off. Two 8-bit control registers are written through a simple write port: a select register naming the fast oscillator, the slow oscillator or the PLL, and an oscillator register holding two enable bits and a 4-bit wait code. Writes take effect only while an external unlock input is high. When the fast oscillator is switched on, a counter runs on the reference clock for a power-of-two number of cycles set by the wait code. The fast-ready flag rises only when that count is complete.

A switch is taken only if the requested source is ready. The fast oscillator is ready once its count is done. The slow oscillator is ready while it is enabled. The PLL is ready while its lock input is high. The oscillator that drives the running clock cannot be switched off. The chosen source leaves the block as a registered 2-bit code for a downstream clock mux. A `TEST_SHIFT` parameter divides every wait by a power of two for short simulations.

Top module: `clksrc_ctrl`

## Requirements
- R1: Synchronous reset sets the selection to the fast oscillator (code 0), the wait code to 0xF and both oscillator enables to 1. The fast-ready flag is 0 until the first count completes.
- R2: While `unlock_i` is low, a write changes no register.
- R3: Source codes are 0 for the fast oscillator, 1 for the slow oscillator and 2 for the PLL. A write of an accepted code appears on `src_sel_o` in the cycle after the write edge.
- R4: A write of source code 3 is ignored, and the previous selection is kept.
- R5: A write naming a source that is not ready in the write cycle is ignored. The fast oscillator is ready when `fast_rdy_o` is 1, the slow one when its enable is 1, and the PLL when `pll_lock_i` is 1.
- R6: Once the fast oscillator is enabled, `fast_rdy_o` rises exactly 2^max(22-code-TEST_SHIFT,0) cycles after the enabling edge. Writing 1 to an enable that is already 1 does not restart the count. With `TEST_SHIFT`=0, code 0xF gives 128 cycles and code 0x0 gives 4,194,304 cycles.
- R7: Clearing an enable drops that oscillator's ready output in the cycle right after the write edge. `slow_rdy_o` equals the slow enable.
- R8: A write that clears the enable of the currently selected oscillator leaves that enable at 1. The other fields of the same write still take effect.
- R9: Read layout at address 0 is {6'b0, select[1:0]}. Read layout at address 1 is {wait[3:0], 2'b00, slow_en, fast_en}. Reserved bits read 0 whatever was written to them. Write data uses the same bit positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| unlock_i | input | 1 | Write permission; writes ignored while low |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 1 | Write target: 0 select register, 1 oscillator register |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 1 | Read target, same decode as write |
| rd_data_o | output | 8 | Read data (combinational) |
| pll_lock_i | input | 1 | PLL locked, treated as PLL ready |
| src_sel_o | output | 2 | Registered source code for the clock mux |
| fast_osc_en_o | output | 1 | Fast oscillator enable |
| slow_osc_en_o | output | 1 | Slow oscillator enable |
| fast_rdy_o | output | 1 | Fast oscillator stable |
| slow_rdy_o | output | 1 | Slow oscillator ready |

## Verification
Several properties are checked on every cycle:
- the select output never carries code 3,
- the selection and the enables stay fixed while the lock is closed,
- every change of selection lands on a source that was ready one cycle earlier,
- a ready flag is never high without its enable,
- the selected oscillator always remains enabled.

Only the bench scenarios can show the exact length of the stabilization wait for a given code, the fact that a redundant enable write does not restart it, and the reserved-bit read values.

// File: rtl/clksrc_pkg.sv
package clksrc_pkg;

    localparam int SEL_W      = 2;
    localparam int WAIT_W     = 4;
    localparam int MAX_EXP    = 22;
    localparam int STAB_CNT_W = MAX_EXP + 1;

    localparam logic ADDR_SEL = 1'b0;
    localparam logic ADDR_OSC = 1'b1;

    typedef enum logic [SEL_W-1:0] {
        SRC_FAST = 2'd0,
        SRC_SLOW = 2'd1,
        SRC_PLL  = 2'd2,
        SRC_BAD  = 2'd3
    } src_e;

    typedef struct packed {
        logic [WAIT_W-1:0] wait_code;
        logic              slow_en;
        logic              fast_en;
    } osc_cfg_t;

    typedef logic [STAB_CNT_W-1:0] lim_t;

    localparam osc_cfg_t CFG_RESET = '{wait_code: 4'hF, slow_en: 1'b1, fast_en: 1'b1};

    // Cycles of stabilization for a wait code, scaled down by 2^shift.
    function automatic lim_t stab_limit(input logic [WAIT_W-1:0] code, input int shift);
        int e;
        e = MAX_EXP - int'(code) - shift;
        if (e < 0) e = 0;
        return lim_t'(1) << e;
    endfunction

    function automatic logic [7:0] pack_osc(input osc_cfg_t c);
        return {c.wait_code, 2'b00, c.slow_en, c.fast_en};
    endfunction

    function automatic logic [7:0] pack_sel(input src_e s);
        return {{(8-SEL_W){1'b0}}, s};
    endfunction

endpackage

// File: rtl/clksrc_stab.sv
module clksrc_stab
    import clksrc_pkg::*;
#(
    parameter int TEST_SHIFT = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [WAIT_W-1:0] wait_code,
    output logic              rdy
);

    lim_t cnt;
    lim_t lim;
    logic rdy_q;

    assign lim = stab_limit(wait_code, TEST_SHIFT);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt   <= '0;
            rdy_q <= 1'b0;
        end else if (!rdy_q) begin
            // >= so that a shortened wait code mid-count still terminates
            if (cnt >= lim - lim_t'(1)) rdy_q <= 1'b1;
            else                        cnt   <= cnt + lim_t'(1);
        end
    end

    // Masking by the enable drops the flag as soon as the enable clears.
    assign rdy = rdy_q & en;

endmodule

// File: rtl/clksrc_regs.sv
module clksrc_regs
    import clksrc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       unlock,
    input  logic       wr_en,
    input  logic       wr_addr,
    input  logic [7:0] wr_data,
    input  logic       fast_rdy,
    input  logic       slow_rdy,
    input  logic       pll_rdy,
    output src_e       sel,
    output osc_cfg_t   cfg
);

    logic wr_ok;
    logic target_ready;
    logic unused_rsvd;

    assign wr_ok       = unlock & wr_en;
    assign unused_rsvd = ^wr_data[3:2];

    always_comb begin
        unique case (wr_data[SEL_W-1:0])
            SRC_FAST: target_ready = fast_rdy;
            SRC_SLOW: target_ready = slow_rdy;
            SRC_PLL:  target_ready = pll_rdy;
            default:  target_ready = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel <= SRC_FAST;
            cfg <= CFG_RESET;
        end else if (wr_ok) begin
            if (wr_addr == ADDR_SEL) begin
                if (target_ready) sel <= src_e'(wr_data[SEL_W-1:0]);
            end else begin
                cfg.wait_code <= wr_data[7:4];
                cfg.slow_en   <= wr_data[1] | (sel == SRC_SLOW);
                cfg.fast_en   <= wr_data[0] | (sel == SRC_FAST);
            end
        end
    end

endmodule

// File: rtl/clksrc_ctrl.sv
module clksrc_ctrl
    import clksrc_pkg::*;
#(
    parameter int TEST_SHIFT = 0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       unlock_i,
    input  logic       wr_en_i,
    input  logic       wr_addr_i,
    input  logic [7:0] wr_data_i,
    input  logic       rd_addr_i,
    output logic [7:0] rd_data_o,
    input  logic       pll_lock_i,
    output logic [1:0] src_sel_o,
    output logic       fast_osc_en_o,
    output logic       slow_osc_en_o,
    output logic       fast_rdy_o,
    output logic       slow_rdy_o
);

    src_e     sel;
    osc_cfg_t cfg;
    logic     fast_rdy;

    clksrc_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .unlock   (unlock_i),
        .wr_en    (wr_en_i),
        .wr_addr  (wr_addr_i),
        .wr_data  (wr_data_i),
        .fast_rdy (fast_rdy),
        .slow_rdy (cfg.slow_en),
        .pll_rdy  (pll_lock_i),
        .sel      (sel),
        .cfg      (cfg)
    );

    clksrc_stab #(.TEST_SHIFT(TEST_SHIFT)) u_stab (
        .clk       (clk),
        .rst       (rst),
        .en        (cfg.fast_en),
        .wait_code (cfg.wait_code),
        .rdy       (fast_rdy)
    );

    assign rd_data_o     = (rd_addr_i == ADDR_OSC) ? pack_osc(cfg) : pack_sel(sel);
    assign src_sel_o     = sel;
    assign fast_osc_en_o = cfg.fast_en;
    assign slow_osc_en_o = cfg.slow_en;
    assign fast_rdy_o    = fast_rdy;
    assign slow_rdy_o    = cfg.slow_en;

endmodule

// File: rtl/clksrc_ctrl_chk.sv
module clksrc_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       unlock_i,
    input logic       pll_lock_i,
    input logic [1:0] src_sel_o,
    input logic       fast_osc_en_o,
    input logic       slow_osc_en_o,
    input logic       fast_rdy_o,
    input logic       slow_rdy_o
);

    // R4: code 3 never reaches the mux
    p_sel_legal_r4: assert property (@(posedge clk) disable iff (rst)
        src_sel_o != 2'd3);

    // R2: closed lock freezes selection and enables
    p_locked_sel_r2: assert property (@(posedge clk) disable iff (rst)
        !unlock_i |=> $stable(src_sel_o));
    p_locked_en_r2: assert property (@(posedge clk) disable iff (rst)
        !unlock_i |=> ($stable(fast_osc_en_o) && $stable(slow_osc_en_o)));

    // R5: a switch lands only on a source that was ready
    p_to_fast_ready_r5: assert property (@(posedge clk) disable iff (rst)
        (src_sel_o == 2'd0 && $past(src_sel_o) != 2'd0) |-> $past(fast_rdy_o));
    p_to_slow_ready_r5: assert property (@(posedge clk) disable iff (rst)
        (src_sel_o == 2'd1 && $past(src_sel_o) != 2'd1) |-> $past(slow_rdy_o));
    p_to_pll_ready_r5: assert property (@(posedge clk) disable iff (rst)
        (src_sel_o == 2'd2 && $past(src_sel_o) != 2'd2) |-> $past(pll_lock_i));

    // R7: no ready flag without its enable
    p_fast_rdy_en_r7: assert property (@(posedge clk) disable iff (rst)
        fast_rdy_o |-> fast_osc_en_o);
    p_slow_rdy_en_r7: assert property (@(posedge clk) disable iff (rst)
        slow_rdy_o |-> slow_osc_en_o);

    // R6: ready rises only after the oscillator has been enabled
    p_rdy_rise_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(fast_rdy_o) |-> $past(fast_osc_en_o));

    // R8: the running oscillator stays on
    p_keep_fast_r8: assert property (@(posedge clk) disable iff (rst)
        (src_sel_o == 2'd0) |-> fast_osc_en_o);
    p_keep_slow_r8: assert property (@(posedge clk) disable iff (rst)
        (src_sel_o == 2'd1) |-> slow_osc_en_o);

endmodule

bind clksrc_ctrl clksrc_ctrl_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .unlock_i      (unlock_i),
    .pll_lock_i    (pll_lock_i),
    .src_sel_o     (src_sel_o),
    .fast_osc_en_o (fast_osc_en_o),
    .slow_osc_en_o (slow_osc_en_o),
    .fast_rdy_o    (fast_rdy_o),
    .slow_rdy_o    (slow_rdy_o)
);

// File: tb/clksrc_ctrl_test.sv
module clksrc_ctrl_test;

    localparam int CLK_P = 10;
    localparam int SHIFT = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       unlock_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic       wr_addr_i = 1'b0;
    logic [7:0] wr_data_i = 8'h00;
    logic       rd_addr_i = 1'b1;
    logic [7:0] rd_data_o;
    logic       pll_lock_i = 1'b0;
    logic [1:0] src_sel_o;
    logic       fast_osc_en_o, slow_osc_en_o, fast_rdy_o, slow_rdy_o;

    clksrc_ctrl #(.TEST_SHIFT(SHIFT)) uut (
        .clk(clk), .rst(rst), .unlock_i(unlock_i), .wr_en_i(wr_en_i),
        .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i),
        .rd_data_o(rd_data_o), .pll_lock_i(pll_lock_i), .src_sel_o(src_sel_o),
        .fast_osc_en_o(fast_osc_en_o), .slow_osc_en_o(slow_osc_en_o),
        .fast_rdy_o(fast_rdy_o), .slow_rdy_o(slow_rdy_o)
    );

    always #(CLK_P/2) clk = ~clk;

    int   n_chk = 0, n_fail = 0;
    bit   done = 1'b0;

    // reference model state
    logic [1:0] m_sel = 2'd0;
    logic [3:0] m_wait = 4'hF;
    logic       m_fen = 1'b1, m_sen = 1'b1, m_frdy = 1'b0;
    int         m_fcnt = 0;

    function automatic int wait_cycles(input logic [3:0] code);
        int e = 22 - int'(code) - SHIFT;
        return (e < 0) ? 1 : (1 << e);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R3 src_sel", 32'(src_sel_o), 32'(m_sel));
        chk("R6 fast_rdy", 32'(fast_rdy_o), 32'(m_frdy & m_fen));
        chk("R7 slow_rdy", 32'(slow_rdy_o), 32'(m_sen));
        chk("R8 fast_en", 32'(fast_osc_en_o), 32'(m_fen));
        chk("R8 slow_en", 32'(slow_osc_en_o), 32'(m_sen));
        chk("R9 read", 32'(rd_data_o),
            rd_addr_i ? 32'({m_wait, 2'b00, m_sen, m_fen}) : 32'({6'b0, m_sel}));
    endtask

    // Called at a negedge; drives, crosses one posedge, returns at the next negedge.
    task automatic tick(input logic we, input logic unl, input logic a,
                        input logic [7:0] d, input logic pll, input logic ra);
        logic       fr_out, ok, n_fen, n_sen;
        logic [1:0] n_sel;
        logic [3:0] n_wait;
        int         n_fcnt;
        wr_en_i = we; unlock_i = unl; wr_addr_i = a; wr_data_i = d;
        pll_lock_i = pll; rd_addr_i = ra;
        @(posedge clk);
        fr_out = m_frdy & m_fen;
        n_sel = m_sel; n_wait = m_wait; n_fen = m_fen; n_sen = m_sen;
        if (we && unl) begin
            if (!a) begin
                case (d[1:0])
                    2'd0: ok = fr_out;
                    2'd1: ok = m_sen;
                    2'd2: ok = pll;
                    default: ok = 1'b0;
                endcase
                if (ok) n_sel = d[1:0];
            end else begin
                n_wait = d[7:4];
                n_sen  = d[1] | (m_sel == 2'd1);
                n_fen  = d[0] | (m_sel == 2'd0);
            end
        end
        n_fcnt = m_fen ? ((m_fcnt < (1 << 24)) ? m_fcnt + 1 : m_fcnt) : 0;
        m_frdy = n_fen & m_fen & (m_frdy | (n_fcnt >= wait_cycles(m_wait)));
        m_fcnt = n_fcnt;
        m_sel = n_sel; m_wait = n_wait; m_fen = n_fen; m_sen = n_sen;
        @(negedge clk);
        wr_en_i = 1'b0;
        compare_all();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(1'b0, 1'b1, 1'b0, 8'h00, pll_lock_i, rd_addr_i);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 sel", 32'(src_sel_o), 32'd0);
        chk("R1 read osc", 32'(rd_data_o), 32'hF3);
        chk("R1 fast_rdy", 32'(fast_rdy_o), 32'd0);
        chk("R1 enables", 32'({fast_osc_en_o, slow_osc_en_o}), 32'b11);

        idle(4);
        chk("R6 ready after default wait", 32'(fast_rdy_o), 32'd1);

        // R2 locked write
        tick(1'b1, 1'b0, 1'b0, 8'h01, 1'b0, 1'b0);
        chk("R2 locked sel", 32'(src_sel_o), 32'd0);
        tick(1'b1, 1'b0, 1'b1, 8'h50, 1'b0, 1'b1);
        chk("R2 locked osc", 32'(rd_data_o), 32'hF3);

        // R5 PLL not locked
        tick(1'b1, 1'b1, 1'b0, 8'h02, 1'b0, 1'b0);
        chk("R5 pll unlocked", 32'(src_sel_o), 32'd0);
        // R3 PLL accepted
        tick(1'b1, 1'b1, 1'b0, 8'h02, 1'b1, 1'b0);
        chk("R3 pll taken", 32'(src_sel_o), 32'd2);
        // R4 code 3
        tick(1'b1, 1'b1, 1'b0, 8'h03, 1'b1, 1'b0);
        chk("R4 code3", 32'(src_sel_o), 32'd2);

        // R7 clear fast enable, wait code 8
        tick(1'b1, 1'b1, 1'b1, 8'h82, 1'b1, 1'b1);
        chk("R7 fast drop", 32'(fast_rdy_o), 32'd0);
        chk("R7 fast en", 32'(fast_osc_en_o), 32'd0);
        // R6 re-enable, exact 256-cycle window
        tick(1'b1, 1'b1, 1'b1, 8'h83, 1'b1, 1'b1);
        tick(1'b1, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0);
        chk("R5 fast not ready", 32'(src_sel_o), 32'd2);
        tick(1'b1, 1'b1, 1'b1, 8'h83, 1'b1, 1'b1); // R6 redundant enable
        idle(253);
        chk("R6 before window end", 32'(fast_rdy_o), 32'd0);
        idle(1);
        chk("R6 at window end", 32'(fast_rdy_o), 32'd1);

        // R3 slow, then R8 try to stop it
        tick(1'b1, 1'b1, 1'b0, 8'h01, 1'b1, 1'b0);
        chk("R3 slow taken", 32'(src_sel_o), 32'd1);
        tick(1'b1, 1'b1, 1'b1, 8'hF1, 1'b1, 1'b1);
        chk("R8 slow kept", 32'(slow_osc_en_o), 32'd1);
        chk("R8 wait updated", 32'(rd_data_o), 32'hF3);
        tick(1'b1, 1'b1, 1'b1, 8'hF2, 1'b1, 1'b1);
        chk("R7 fast drop at once", 32'(fast_rdy_o), 32'd0);

        // R9 reserved bits
        tick(1'b1, 1'b1, 1'b1, 8'hFF, 1'b1, 1'b1);
        chk("R9 osc reserved", 32'(rd_data_o), 32'hF3);
        idle(3);
        tick(1'b1, 1'b1, 1'b0, 8'hFC, 1'b1, 1'b0);
        chk("R9 sel reserved", 32'(rd_data_o), 32'h00);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            logic [7:0] d = 8'($urandom);
            if ($urandom % 2) d[7:4] = 4'(9 + $urandom % 7);
            else              d[7:4] = 4'hF;
            tick(1'($urandom % 3 == 0), 1'($urandom % 4 != 0), 1'($urandom),
                 d, ($urandom % 8 == 0) ? ~pll_lock_i : pll_lock_i, 1'($urandom));
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule